// File: doc/BRIEF.md
# Keyed Real-Time Clock with Alarm

The block keeps a 32-bit count of elapsed seconds. A prescaler turns the input clock into one pulse per second. The prescaler's terminal count follows a source-select bit, which chooses between a 20 MHz input and a 4 MHz input. A 32-bit alarm value is compared with the count at all times.

Two sticky status flags record events:
- a seconds flag, set on every tick;
- an alarm flag, set when the count becomes equal to the alarm value.

Software clears each flag by writing 1 to it. Each flag has its own enable that decides whether it drives the interrupt request. An 8-bit priority level is held in the control register and driven out unchanged.

The count and alarm registers are write-protected from reset onward. Software opens them by writing a fixed key to the key register, and closes them again by writing any other value there. A freeze input can halt counting, but only when the freeze-enable bit is set.

Top module: `rtc_keyed`

## Requirements
- R1: Register select on `bus_addr`: 0 is control/status, 1 is seconds count, 2 is alarm, 3 is key. Reads are combinational on `bus_rdata`, and the key register reads 0. After reset the control/status, count and alarm registers all read 0 and `irq` is 0.
- R2: After reset, writes to the count and alarm registers are ignored. Writing 0x55CCAA33 to the key register opens both for writing. Writing any other value to the key register closes them again.
- R3: An accepted count write loads the value and clears the prescaler. The next increment therefore comes exactly one full divider period after the write edge, and a write takes precedence over a tick in the same cycle.
- R4: Control bit 4 selects the source. At 0 a second lasts DIV_FAST clock cycles (default 20,000,000); at 1 it lasts DIV_SLOW cycles (default 4,000,000).
- R5: Control bit 7, the seconds flag, is set on the edge where the count increments. It stays set until 1 is written to bit 7.
- R6: Control bit 6, the alarm flag, is set one cycle after the count becomes equal to the alarm value. It is cleared by writing 1 to bit 6.
- R7: A tick or alarm match in the same cycle as a write-1-to-clear leaves the flag set.
- R8: `irq` is high exactly when bit 7 and its enable (bit 3) are both set, or when bit 6 and its enable (bit 2) are both set.
- R9: With control bit 1 (freeze enable) set, counting halts while `freeze_in` is high. With bit 1 clear, `freeze_in` has no effect.
- R10: Control bit 0 runs the clock. While it is 0, the count and the prescaler hold their values.
- R11: Control bits 31:24 are driven unchanged on `irq_level`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that drives the prescaler |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register |
| freeze_in | input | 1 | External freeze request |
| irq | output | 1 | Interrupt request |
| irq_level | output | 8 | Interrupt priority level |

## Verification
The properties assume that `freeze_in`, `bus_we`, `bus_addr` and `bus_wdata` are synchronous to `clk`. They also assume that DIV_FAST is at least DIV_SLOW, so the prescaler range is set by DIV_FAST. The bench drives every input at the falling edge and runs small divisors (10 and 4), so a whole second can be swept cycle by cycle.

Only write-1-to-clear strobes are timed to land on a tick edge. The expected count is always derived from the number of edges since the last count write, which keeps the stimulus within the model's assumption that a count write restarts the second.

// File: rtl/rtc_pkg.sv
// rtc_pkg: register selects, unlock key and control-bit positions shared by
// the keyed real-time clock and its checker.
package rtc_pkg;
    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_COUNT = 2'd1,
        REG_ALARM = 2'd2,
        REG_KEY   = 2'd3
    } rtc_reg_e;

    localparam logic [31:0] UNLOCK_KEY = 32'h55CC_AA33;

    localparam int BIT_RUN  = 0;
    localparam int BIT_FRZ  = 1;
    localparam int BIT_AIE  = 2;
    localparam int BIT_SIE  = 3;
    localparam int BIT_SLOW = 4;
    localparam int BIT_AFLG = 6;
    localparam int BIT_SFLG = 7;
    localparam int LVL_LSB  = 24;
    localparam int LVL_W    = 8;
endpackage

// File: rtl/rtc_prescaler.sv
// rtc_prescaler: divides the input clock into one-cycle second ticks.
// Assumes DIV_FAST >= DIV_SLOW >= 2. A clear restarts the second and
// suppresses a tick in the same cycle. A count left above the slow terminal
// after a source switch wraps at once.
module rtc_prescaler #(
    parameter int DIV_FAST = 20_000_000,
    parameter int DIV_SLOW = 4_000_000,
    localparam int W = $clog2(DIV_FAST)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         advance,
    input  logic         slow,
    input  logic         clear,
    output logic         tick,
    output logic [W-1:0] phase
);
    localparam logic [W-1:0] TERM_FAST = W'(DIV_FAST - 1);
    localparam logic [W-1:0] TERM_SLOW = W'(DIV_SLOW - 1);

    logic at_term;

    // Terminal detect for the selected source.
    always_comb begin
        at_term = slow ? (phase >= TERM_SLOW) : (phase >= TERM_FAST);
        tick    = advance && !clear && at_term;
    end

    // Sub-second counter: clear, wrap on terminal, or step.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase <= '0;
        else if (clear)   phase <= '0;
        else if (advance) phase <= at_term ? '0 : phase + 1'b1;
    end
endmodule

// File: rtl/rtc_keylock.sv
// rtc_keylock: write-protection latch. The key value opens the protected
// registers; any other value written to the key register closes them.
// Reset leaves the latch closed.
module rtc_keylock #(
    parameter logic [31:0] KEY = 32'h55CC_AA33
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_wr,
    input  logic [31:0] key_data,
    output logic        unlocked
);
    // Latch state follows the last value written to the key register.
    always_ff @(posedge clk) begin
        if (!rst_n)      unlocked <= 1'b0;
        else if (key_wr) unlocked <= (key_data == KEY);
    end
endmodule

// File: rtl/rtc_keyed.sv
// rtc_keyed: seconds counter with alarm compare, sticky write-1-to-clear
// flags, an interrupt gated per flag, and key-protected count and alarm
// registers. Assumes the bus signals and freeze_in are synchronous to clk,
// and that DIV_FAST >= DIV_SLOW.
module rtc_keyed
    import rtc_pkg::*;
#(
    parameter int DIV_FAST = 20_000_000,
    parameter int DIV_SLOW = 4_000_000,
    localparam int PW = $clog2(DIV_FAST)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic             freeze_in,
    output logic             irq,
    output logic [LVL_W-1:0] irq_level
);
    logic [31:0]      count_q, alarm_q;
    logic             run_q, frz_q, aie_q, sie_q, slow_q;
    logic             sec_flag, alm_flag, match_q;
    logic [LVL_W-1:0] level_q;
    logic             unlocked, tick, frz_halt, advance;
    logic             ctrl_wr, cnt_wr, alm_wr, key_wr, match_now;
    logic [PW-1:0]    phase;

    // Write decode; protected registers also need the latch open.
    always_comb begin
        ctrl_wr   = bus_we && (bus_addr == REG_CTRL);
        key_wr    = bus_we && (bus_addr == REG_KEY);
        cnt_wr    = bus_we && (bus_addr == REG_COUNT) && unlocked;
        alm_wr    = bus_we && (bus_addr == REG_ALARM) && unlocked;
        frz_halt  = frz_q && freeze_in;
        advance   = run_q && !frz_halt;
        match_now = (count_q == alarm_q);
    end

    rtc_keylock #(.KEY(UNLOCK_KEY)) u_lock (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr),
        .key_data(bus_wdata), .unlocked(unlocked)
    );

    rtc_prescaler #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_presc (
        .clk(clk), .rst_n(rst_n), .advance(advance), .slow(slow_q),
        .clear(cnt_wr), .tick(tick), .phase(phase)
    );

    // Seconds count: a write wins over a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      count_q <= '0;
        else if (cnt_wr) count_q <= bus_wdata;
        else if (tick)   count_q <= count_q + 32'd1;
    end

    // Alarm value register.
    always_ff @(posedge clk) begin
        if (!rst_n)      alarm_q <= '0;
        else if (alm_wr) alarm_q <= bus_wdata;
    end

    // Control fields, loaded whole on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {run_q, frz_q, aie_q, sie_q, slow_q} <= '0;
            level_q <= '0;
        end else if (ctrl_wr) begin
            run_q   <= bus_wdata[BIT_RUN];
            frz_q   <= bus_wdata[BIT_FRZ];
            aie_q   <= bus_wdata[BIT_AIE];
            sie_q   <= bus_wdata[BIT_SIE];
            slow_q  <= bus_wdata[BIT_SLOW];
            level_q <= bus_wdata[LVL_LSB +: LVL_W];
        end
    end

    // Sticky flags: a set event beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_flag <= 1'b0;
            alm_flag <= 1'b0;
            match_q  <= 1'b1;
        end else begin
            match_q <= match_now;
            if (tick)                               sec_flag <= 1'b1;
            else if (ctrl_wr && bus_wdata[BIT_SFLG]) sec_flag <= 1'b0;
            if (match_now && !match_q)              alm_flag <= 1'b1;
            else if (ctrl_wr && bus_wdata[BIT_AFLG]) alm_flag <= 1'b0;
        end
    end

    // Interrupt, priority level and read mux.
    always_comb begin
        irq       = (sec_flag && sie_q) || (alm_flag && aie_q);
        irq_level = level_q;
        unique case (rtc_reg_e'(bus_addr))
            REG_CTRL:  bus_rdata = {level_q, 16'd0, sec_flag, alm_flag, 1'b0,
                                    slow_q, sie_q, aie_q, frz_q, run_q};
            REG_COUNT: bus_rdata = count_q;
            REG_ALARM: bus_rdata = alarm_q;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtc_keyed_chk.sv
// rtc_keyed_chk: temporal properties of the keyed clock, bound into every
// rtc_keyed instance.
module rtc_keyed_chk #(
    parameter int DIV_FAST = 20_000_000,
    localparam int PW = $clog2(DIV_FAST)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cnt_wr,
    input logic          tick,
    input logic          frz_halt,
    input logic          unlocked,
    input logic [31:0]   count_q,
    input logic [31:0]   alarm_q,
    input logic [PW-1:0] phase,
    input logic          sec_flag,
    input logic          alm_flag,
    input logic          irq
);
    // R2
    locked_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && !tick) |=> $stable(count_q));
    // R2
    locked_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(alarm_q));
    // R3
    presc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (phase == '0));
    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> (count_q == $past(count_q) || count_q == $past(count_q) + 32'd1));
    // R4
    presc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(phase) < DIV_FAST);
    // R5
    sec_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> sec_flag);
    // R9
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_halt && !cnt_wr) |=> $stable(count_q));
    // R8
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (sec_flag || alm_flag));
endmodule

bind rtc_keyed rtc_keyed_chk #(.DIV_FAST(DIV_FAST)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .tick(tick),
    .frz_halt(frz_halt), .unlocked(unlocked), .count_q(count_q),
    .alarm_q(alarm_q), .phase(phase), .sec_flag(sec_flag),
    .alm_flag(alm_flag), .irq(irq)
);

// File: tb/test_rtc_keyed.sv
module test_rtc_keyed;
    localparam int CLK_PERIOD = 10;
    localparam int DF = 10;
    localparam int DS = 4;
    localparam logic [31:0] KEY = 32'h55CC_AA33;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        freeze_in = 1'b0;
    logic        irq;
    logic [7:0]  irq_level;

    int checks = 0;
    int errors = 0;

    rtc_keyed #(.DIV_FAST(DF), .DIV_SLOW(DS)) i_rtc_keyed (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .freeze_in(freeze_in),
        .irq(irq), .irq_level(irq_level)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; the write lands on the next rising edge.
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Sweep: expected count is base plus whole seconds since the write edge.
    task automatic sweep(input int div, input logic [31:0] base, input int secs, input string req);
        logic [31:0] v;
        wr(2'd1, base);
        for (int t = 1; t <= secs * div + 2; t++) begin
            @(negedge clk);
            rd(2'd1, v);
            chk(req, v, base + 32'(t / div));
            rd(2'd0, v);
            chk("R5", {31'd0, v[7]}, {31'd0, t >= div});
            chk("R8", {31'd0, irq}, {31'd0, t >= div});
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        rd(2'd0, v); chk("R1", v, 32'd0);
        rd(2'd1, v); chk("R1", v, 32'd0);
        rd(2'd2, v); chk("R1", v, 32'd0);
        rd(2'd3, v); chk("R1", v, 32'd0);
        chk("R1", {31'd0, irq}, 32'd0);
        // R2 locked after reset
        wr(2'd1, 32'd77); rd(2'd1, v); chk("R2", v, 32'd0);
        wr(2'd2, 32'd9);  rd(2'd2, v); chk("R2", v, 32'd0);
        wr(2'd3, KEY);
        wr(2'd1, 32'd100); rd(2'd1, v); chk("R2", v, 32'd100);
        // R10 stopped clock holds
        repeat (3 * DF) @(negedge clk);
        rd(2'd1, v); chk("R10", v, 32'd100);
        // R11 level pass-through, fast source with seconds interrupt
        wr(2'd0, 32'hA500_0009);
        chk("R11", {24'd0, irq_level}, 32'hA5);
        sweep(DF, 32'd200, 3, "R4");
        // R5 write-1-to-clear
        wr(2'd0, 32'hA500_0089);
        rd(2'd0, v); chk("R5", {31'd0, v[7]}, 32'd0);
        chk("R8", {31'd0, irq}, 32'd0);
        // R4 slow source
        wr(2'd0, 32'h0000_0019);
        sweep(DS, 32'd50, 3, "R3");
        // R7 set beats clear on the tick edge
        wr(2'd0, 32'h0000_0091);
        wr(2'd1, 32'd10);
        repeat (DS - 1) @(negedge clk);
        wr(2'd0, 32'h0000_0091);
        rd(2'd0, v); chk("R7", {31'd0, v[7]}, 32'd1);
        rd(2'd1, v); chk("R7", v, 32'd11);
        // R6 alarm: flag one cycle after count equals alarm
        wr(2'd0, 32'h0000_00D5);
        wr(2'd2, 32'd22);
        wr(2'd1, 32'd20);
        for (int t = 1; t <= 2 * DS + 3; t++) begin
            @(negedge clk);
            rd(2'd0, v);
            chk("R6", {31'd0, v[6]}, {31'd0, t >= 2 * DS + 1});
            chk("R8", {31'd0, irq}, {31'd0, t >= 2 * DS + 1});
        end
        // R9 freeze with enable halts counting
        wr(2'd0, 32'h0000_0013);
        wr(2'd1, 32'd30);
        freeze_in = 1'b1;
        repeat (5 * DS) @(negedge clk);
        rd(2'd1, v); chk("R9", v, 32'd30);
        // R9 freeze without enable has no effect
        wr(2'd0, 32'h0000_0011);
        wr(2'd1, 32'd40);
        repeat (DS) @(negedge clk);
        rd(2'd1, v); chk("R9", v, 32'd41);
        freeze_in = 1'b0;
        // R10 clearing run stops the count
        wr(2'd0, 32'h0000_0010);
        wr(2'd1, 32'd60);
        repeat (5 * DS) @(negedge clk);
        rd(2'd1, v); chk("R10", v, 32'd60);
        // R2 wrong key relocks
        wr(2'd3, 32'h1234_5678);
        wr(2'd1, 32'd5); rd(2'd1, v); chk("R2", v, 32'd60);
        wr(2'd2, 32'd1); rd(2'd2, v); chk("R2", v, 32'd22);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule